// File: doc/BRIEF.md
# Radix-2 In-Place FFT Butterfly Sequencer

This block drives the control side of an N-point in-place radix-2 decimation-in-time FFT, with N = 2^L. One start pulse makes it walk through all L stages and present one butterfly at a time to a datapath over a valid/ready handshake. For each butterfly it gives the index of the upper operand, the index of the lower operand, the index into a twiddle table, and the source addresses the operands are read from. It also raises flags for the first stage, for the last stage, and for bit-reversed source reads. The memories and the complex arithmetic sit outside the block.

Inside a stage s, butterflies are grouped by twiddle value. Every butterfly that uses twiddle k is issued, across all groups, before the sequencer moves on to twiddle k+1. The twiddle step is N/2^s, so it halves from one stage to the next. Stage 1 reads its operands through a bit reversal of the index and uses no twiddle multiply. The last stage is flagged so that the datapath can apply its final scaling shift. After the final butterfly is accepted, a one-cycle done pulse ends the run.

Top module: `fft_stage_seq`

## Requirements
- R1: After reset, bf_valid and done are both low, and they stay low until start is seen.
- R2: When start is high at a clock edge while the block is idle, bf_valid rises after that edge. The first butterfly presented is stage 1 with top 0, bottom 1 and twiddle 0.
- R3: Stages are issued in order 1 to L. In stage s, with n1 = 2^s and n2 = n1/2, k runs from 1 to n2. For each k, top index i takes the values k-1, k-1+n1, ... while i < N, and the bottom index is i + n2.
- R4: The twiddle index for twiddle k in stage s is (k-1)·N/2^s, taking values in 0 to N/2-1. Every butterfly of stage 1 therefore carries twiddle 0.
- R5: In stage 1, bitrev_sel is 1 and src_top_idx and src_bot_idx are the L-bit bit reversals of top_idx and bot_idx (bit b moves to bit L-1-b). In all other stages, bitrev_sel is 0 and the source indices equal top_idx and bot_idx.
- R6: first_stage is 1 exactly during stage 1 and last_stage is 1 exactly during stage L.
- R7: While bf_valid is high and bf_ready is low, every output holds its value and bf_valid stays high. The sequencer advances only on a cycle where both are high.
- R8: After the L·N/2-th butterfly is accepted, done is high for exactly one cycle, and bf_valid is low during that cycle.
- R9: start has no effect while a run is in progress or while done is high. Neither case restarts the sequence or produces extra butterflies.
- R10: A start seen after done has been issued begins a fresh run from stage 1, top 0 and twiddle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| bf_ready | input | 1 | Datapath accepts the presented butterfly |
| bf_valid | output | 1 | A butterfly is presented |
| top_idx | output | L | Upper operand index i (write address) |
| bot_idx | output | L | Lower operand index i + n2 (write address) |
| src_top_idx | output | L | Read address for the upper operand |
| src_bot_idx | output | L | Read address for the lower operand |
| twid_idx | output | L-1 | Twiddle table index |
| first_stage | output | 1 | Butterfly belongs to stage 1 |
| last_stage | output | 1 | Butterfly belongs to stage L |
| bitrev_sel | output | 1 | Source addresses are bit-reversed |
| done | output | 1 | One-cycle pulse after the final butterfly is accepted |

## Verification
The bench sweeps L = 3, 4, 5 and 6 and compares every presented tuple against a nested-loop model. Two boundaries matter most. One is the wrap from the last group of one twiddle to the first index of the next twiddle: a design that restarts i at 0 there, or forgets to add the twiddle step, repeats or skips butterflies. The other is the move between stages: the twiddle step must halve at that point, or phi walks off its table. Stalls with start held high test that outputs stay frozen and that no restart happens; a design that advances on valid alone would drop butterflies. The bench also checks that the done pulse falls exactly one cycle after the final acceptance, that start during done is ignored, and that a second run begins cleanly. The bit-reversed source addresses of stage 1 are checked against a reversal computed a different way, and the bench checks that they revert to linear addresses in stage 2.

// File: rtl/fftseq_pkg.sv
package fftseq_pkg;

  localparam int unsigned MAX_AW = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  // reverse the low nb bits of v; bits above nb come out zero
  function automatic logic [MAX_AW-1:0] rev_bits(input logic [MAX_AW-1:0] v,
                                                 input int unsigned nb);
    logic [MAX_AW-1:0] r;
    r = '0;
    for (int unsigned b = 0; b < MAX_AW; b++) begin
      if (b < nb) r[nb-1-b] = v[b];
    end
    return r;
  endfunction

  // low bits that must be zero in a twiddle index of stage s
  function automatic int unsigned phi_zero_bits(input int unsigned l,
                                                input int unsigned s);
    return l - s;
  endfunction

endpackage

// File: rtl/fftseq_ctrl.sv
module fftseq_ctrl
  import fftseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ready,
  input  logic last_bfly,
  output logic valid,
  output logic done,
  output logic clear,
  output logic step
);

  seq_state_e st_q, st_d;

  always_comb begin
    valid = (st_q == SEQ_RUN);
    done  = (st_q == SEQ_DONE);
    clear = (st_q == SEQ_IDLE) && start;
    step  = valid && ready;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      SEQ_IDLE: if (start) st_d = SEQ_RUN;
      SEQ_RUN:  if (ready && last_bfly) st_d = SEQ_DONE;
      SEQ_DONE: st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/fftseq_walk.sv
module fftseq_walk #(
  parameter int L = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     step,
  output logic [$clog2(L+1)-1:0]   stage_o,
  output logic [L-1:0]             idx_o,
  output logic [L-1:0]             half_o,
  output logic [L-2:0]             phi_o,
  output logic                     last_o
);

  localparam int N  = 1 << L;
  localparam int CW = L + 1;
  localparam int SW = $clog2(L + 1);
  localparam int PW = L - 1;

  logic [SW-1:0] stage_q;
  logic [L-1:0]  i_q;
  logic [L-1:0]  k0_q;
  logic [PW-1:0] phi_q;

  logic [CW-1:0] span;
  logic [CW-1:0] gap;
  logic [CW-1:0] i_adv;
  logic [PW-1:0] offs;
  logic          grp_end;
  logic          k_end;

  always_comb begin
    span    = CW'(1) << stage_q;
    gap     = span >> 1;
    i_adv   = {1'b0, i_q} + span;
    grp_end = i_adv[L];
    k_end   = ({1'b0, k0_q} + CW'(1)) == gap;
    // only used from stage 2 onward, where N/2^s fits in PW bits
    offs    = PW'(N >> 2) >> (stage_q - SW'(2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= SW'(1);
      i_q     <= '0;
      k0_q    <= '0;
      phi_q   <= '0;
    end else if (clear) begin
      stage_q <= SW'(1);
      i_q     <= '0;
      k0_q    <= '0;
      phi_q   <= '0;
    end else if (step) begin
      if (!grp_end) begin
        i_q <= i_adv[L-1:0];
      end else if (!k_end) begin
        k0_q  <= k0_q + L'(1);
        i_q   <= k0_q + L'(1);
        phi_q <= phi_q + offs;
      end else begin
        stage_q <= stage_q + SW'(1);
        k0_q    <= '0;
        i_q     <= '0;
        phi_q   <= '0;
      end
    end
  end

  assign stage_o = stage_q;
  assign idx_o   = i_q;
  assign half_o  = gap[L-1:0];
  assign phi_o   = phi_q;
  assign last_o  = grp_end && k_end && (stage_q == SW'(L));

endmodule

// File: rtl/fftseq_addr.sv
module fftseq_addr #(
  parameter int L = 5
) (
  input  logic [$clog2(L+1)-1:0] stage,
  input  logic [L-1:0]           idx,
  input  logic [L-1:0]           half,
  output logic [L-1:0]           top,
  output logic [L-1:0]           bot,
  output logic [L-1:0]           src_top,
  output logic [L-1:0]           src_bot,
  output logic                   first,
  output logic                   last
);

  localparam int SW = $clog2(L + 1);

  logic [L-1:0] top_rev;
  logic [L-1:0] bot_rev;

  assign top = idx;
  assign bot = idx + half;

  for (genvar g = 0; g < L; g++) begin : g_rev
    assign top_rev[g] = top[L-1-g];
    assign bot_rev[g] = bot[L-1-g];
  end

  assign first   = (stage == SW'(1));
  assign last    = (stage == SW'(L));
  assign src_top = first ? top_rev : top;
  assign src_bot = first ? bot_rev : bot;

endmodule

// File: rtl/fft_stage_seq.sv
module fft_stage_seq #(
  parameter int L = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         bf_ready,
  output logic         bf_valid,
  output logic [L-1:0] top_idx,
  output logic [L-1:0] bot_idx,
  output logic [L-1:0] src_top_idx,
  output logic [L-1:0] src_bot_idx,
  output logic [L-2:0] twid_idx,
  output logic         first_stage,
  output logic         last_stage,
  output logic         bitrev_sel,
  output logic         done
);

  localparam int SW = $clog2(L + 1);

  // named internal events, visible to the bound checker
  logic [SW-1:0] cur_stage;
  logic [L-1:0]  cur_idx;
  logic [L-1:0]  cur_half;
  logic          last_bfly;
  logic          accept;
  logic          final_accept;
  logic          run_clear;

  fftseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready     (bf_ready),
    .last_bfly (last_bfly),
    .valid     (bf_valid),
    .done      (done),
    .clear     (run_clear),
    .step      (accept)
  );

  fftseq_walk #(.L(L)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (run_clear),
    .step    (accept),
    .stage_o (cur_stage),
    .idx_o   (cur_idx),
    .half_o  (cur_half),
    .phi_o   (twid_idx),
    .last_o  (last_bfly)
  );

  fftseq_addr #(.L(L)) u_addr (
    .stage   (cur_stage),
    .idx     (cur_idx),
    .half    (cur_half),
    .top     (top_idx),
    .bot     (bot_idx),
    .src_top (src_top_idx),
    .src_bot (src_bot_idx),
    .first   (first_stage),
    .last    (last_stage)
  );

  assign bitrev_sel   = first_stage;
  assign final_accept = accept && last_bfly;

endmodule

// File: rtl/fft_stage_seq_chk.sv
module fft_stage_seq_chk
  import fftseq_pkg::*;
#(
  parameter int L = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bf_valid,
  input logic                   bf_ready,
  input logic [L-1:0]           top_idx,
  input logic [L-1:0]           bot_idx,
  input logic [L-1:0]           src_top_idx,
  input logic [L-1:0]           src_bot_idx,
  input logic [L-2:0]           twid_idx,
  input logic                   first_stage,
  input logic                   last_stage,
  input logic                   bitrev_sel,
  input logic                   done,
  input logic [$clog2(L+1)-1:0] cur_stage,
  input logic                   accept,
  input logic                   final_accept
);

  localparam int PW = L - 1;

  logic [L-1:0]      exp_gap;
  logic [PW-1:0]     phi_mask;
  logic [MAX_AW-1:0] rt_full;
  logic [MAX_AW-1:0] rb_full;

  always_comb begin
    exp_gap  = L'(1) << (cur_stage - 1'b1);
    phi_mask = (PW'(1) << phi_zero_bits(L, int'(cur_stage))) - PW'(1);
    rt_full  = rev_bits(MAX_AW'(top_idx), L);
    rb_full  = rev_bits(MAX_AW'(bot_idx), L);
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bf_valid && !bf_ready |=> bf_valid && $stable(top_idx) && $stable(bot_idx)
      && $stable(twid_idx) && $stable(first_stage) && $stable(last_stage));

  a_r3_distance: assert property (@(posedge clk) disable iff (!rst_n)
    bf_valid |-> L'(bot_idx - top_idx) == exp_gap);

  a_r3_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !final_accept |=> bf_valid &&
      (cur_stage == $past(cur_stage) || cur_stage == $past(cur_stage) + 1'b1));

  a_r4_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bf_valid && first_stage |-> twid_idx == '0);

  a_r4_phi_align: assert property (@(posedge clk) disable iff (!rst_n)
    bf_valid |-> (twid_idx & phi_mask) == '0);

  a_r5_bitrev: assert property (@(posedge clk) disable iff (!rst_n)
    bf_valid && bitrev_sel |->
      src_top_idx == rt_full[L-1:0] && src_bot_idx == rb_full[L-1:0]);

  a_r5_linear: assert property (@(posedge clk) disable iff (!rst_n)
    bf_valid && !bitrev_sel |-> src_top_idx == top_idx && src_bot_idx == bot_idx);

  a_r6_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
    bf_valid |-> !(first_stage && last_stage));

  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    final_accept |=> done && !bf_valid);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_no_restart_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !bf_valid);

endmodule

bind fft_stage_seq fft_stage_seq_chk #(.L(L)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bf_valid     (bf_valid),
  .bf_ready     (bf_ready),
  .top_idx      (top_idx),
  .bot_idx      (bot_idx),
  .src_top_idx  (src_top_idx),
  .src_bot_idx  (src_bot_idx),
  .twid_idx     (twid_idx),
  .first_stage  (first_stage),
  .last_stage   (last_stage),
  .bitrev_sel   (bitrev_sel),
  .done         (done),
  .cur_stage    (cur_stage),
  .accept       (accept),
  .final_accept (final_accept)
);

// File: tb/sim_fft_stage_seq.sv
module seq_probe #(
  parameter int L = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic fin,
  output int   nrun,
  output int   nfail
);

  localparam int N = 1 << L;

  logic         start;
  logic         bf_ready;
  logic         bf_valid;
  logic [L-1:0] top_idx, bot_idx, src_top_idx, src_bot_idx;
  logic [L-2:0] twid_idx;
  logic         first_stage, last_stage, bitrev_sel, done;

  fft_stage_seq #(.L(L)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .bf_ready    (bf_ready),
    .bf_valid    (bf_valid),
    .top_idx     (top_idx),
    .bot_idx     (bot_idx),
    .src_top_idx (src_top_idx),
    .src_bot_idx (src_bot_idx),
    .twid_idx    (twid_idx),
    .first_stage (first_stage),
    .last_stage  (last_stage),
    .bitrev_sel  (bitrev_sel),
    .done        (done)
  );

  function automatic int flip(input int v);
    int r = 0;
    int x = v;
    for (int n = 0; n < L; n++) begin
      r = (r << 1) | (x & 1);
      x = x >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s L=%0d actual=%0d expected=%0d", tag, L, act, exp);
    end
  endtask

  task automatic chk_tuple(input int i, input int n2, input int phi, input int s);
    int b = i + n2;
    chk(bf_valid == 1'b1, "R3 valid", int'(bf_valid), 1);
    chk(int'(top_idx) == i, "R3 top", int'(top_idx), i);
    chk(int'(bot_idx) == b, "R3 bottom", int'(bot_idx), b);
    chk(int'(twid_idx) == phi, "R4 twiddle", int'(twid_idx), phi);
    chk(first_stage == (s == 1), "R6 first flag", int'(first_stage), int'(s == 1));
    chk(last_stage == (s == L), "R6 last flag", int'(last_stage), int'(s == L));
    chk(bitrev_sel == (s == 1), "R5 bitrev flag", int'(bitrev_sel), int'(s == 1));
    if (s == 1) begin
      chk(int'(src_top_idx) == flip(i), "R5 src top", int'(src_top_idx), flip(i));
      chk(int'(src_bot_idx) == flip(b), "R5 src bottom", int'(src_bot_idx), flip(b));
    end else begin
      chk(int'(src_top_idx) == i, "R5 src top linear", int'(src_top_idx), i);
      chk(int'(src_bot_idx) == b, "R5 src bottom linear", int'(src_bot_idx), b);
    end
  endtask

  task automatic run_seq(input bit stalls);
    int cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: first butterfly right after start
    chk(bf_valid && top_idx == '0 && bot_idx == L'(1) && twid_idx == '0,
        "R2 first tuple", int'(top_idx), 0);
    for (int s = 1; s <= L; s++) begin
      int n1 = 1 << s;
      int n2 = n1 / 2;
      int off = N >> s;
      int phi = 0;
      for (int k = 1; k <= n2; k++) begin
        for (int i = k - 1; i < N; i += n1) begin
          if (stalls && (cnt % 7) == 3) begin
            bf_ready = 1'b0;
            start = 1'b1;
            chk_tuple(i, n2, phi, s);
            @(negedge clk);
            start = 1'b0;
            // R7 hold, R9 start ignored while running
            chk(bf_valid && int'(top_idx) == i && int'(twid_idx) == phi,
                "R7 hold under stall", int'(top_idx), i);
            chk(!done, "R9 start during run", int'(done), 0);
          end
          bf_ready = 1'b1;
          chk_tuple(i, n2, phi, s);
          cnt++;
          @(negedge clk);
        end
        phi += off;
      end
    end
    chk(cnt == L * N / 2, "R8 butterfly count", cnt, L * N / 2);
    chk(done == 1'b1, "R8 done pulse", int'(done), 1);
    chk(bf_valid == 1'b0, "R8 valid low with done", int'(bf_valid), 0);
    bf_ready = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    chk(bf_valid == 1'b0, "R9 start during done ignored", int'(bf_valid), 0);
    @(negedge clk);
    chk(bf_valid == 1'b0 && done == 1'b0, "R9 stays idle", int'(bf_valid), 0);
  endtask

  initial begin
    fin = 1'b0;
    nrun = 0;
    nfail = 0;
    start = 1'b0;
    bf_ready = 1'b0;
    @(posedge rst_n);
    @(negedge clk);
    chk(bf_valid == 1'b0, "R1 reset valid", int'(bf_valid), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    @(negedge clk);
    chk(bf_valid == 1'b0, "R1 idle without start", int'(bf_valid), 0);
    run_seq(1'b1);
    // R10: second run restarts from stage 1
    run_seq(1'b0);
    fin = 1'b1;
  end

endmodule

module sim_fft_stage_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  always #2.5 clk = ~clk;

  logic fin3, fin4, fin5, fin6;
  int   r3n, r4n, r5n, r6n;
  int   f3n, f4n, f5n, f6n;

  seq_probe #(.L(3)) p3 (.clk(clk), .rst_n(rst_n), .fin(fin3), .nrun(r3n), .nfail(f3n));
  seq_probe #(.L(4)) p4 (.clk(clk), .rst_n(rst_n), .fin(fin4), .nrun(r4n), .nfail(f4n));
  seq_probe #(.L(5)) p5 (.clk(clk), .rst_n(rst_n), .fin(fin5), .nrun(r5n), .nfail(f5n));
  seq_probe #(.L(6)) p6 (.clk(clk), .rst_n(rst_n), .fin(fin6), .nrun(r6n), .nfail(f6n));

  initial begin
    int extra_fail = 0;
    int cyc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    while (!(fin3 && fin4 && fin5 && fin6) && cyc < 100000) begin
      @(negedge clk);
      cyc++;
    end
    if (!(fin3 && fin4 && fin5 && fin6)) begin
      extra_fail = 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected=%0d", cyc, 0);
    end
    $display("  [TB] %0d tests run, %0d failed",
             r3n + r4n + r5n + r6n + extra_fail,
             f3n + f4n + f5n + f6n + extra_fail);
    $finish;
  end

endmodule